// File: doc/BRIEF.md
# Gapped Stride Copy Engine

This engine moves a block of bytes from one region of memory to another. Each side has its own layout: the source is read as lines of a programmed width, separated by a programmed gap that is skipped, and the destination is written in the same way with its own width and gap. The two layouts are independent. A source line may end in the middle of a destination line, or the other way round, and each pointer skips its own gap only when its own line runs out.

Software writes the two base addresses, the byte count and the geometry word, then sets the start bit. The engine moves data in 16-byte beats. For each beat it sends a read request, takes the returned beat and writes it out with a byte strobe. Line widths and gaps are whole beats and base addresses are beat-aligned, so every line end falls on a beat boundary. Only the final beat can be partial. On completion the start bit drops, the done flag is set and the interrupt line is driven high until software clears it.

Top module: `gsc_dma`

## Requirements
- R1: After reset, irq is low, no read or write request is valid, and every register reads as zero.
- R2: Register words are selected by cfg_addr. 0 is the source base and 1 is the destination base; bits [3:0] of both are held at zero. 2 is the byte count, using the low SIZE_W bits. 3 is the geometry word: [7:0] source line width, [15:8] source gap, [23:16] destination line width, [31:24] destination gap, all in 16-byte beats. 4 is control/status: bit0 start (reads 1 while a transfer is pending), bit1 busy, bit2 error, bit3 done.
- R3: Each beat is read from the current source address and written unchanged to the current destination address. The strobe is all ones except on the final beat, which enables only the low (count mod 16) bytes; when the count is a multiple of 16, the final strobe is all ones.
- R4: After a source line's width of beats, the next read address is the line's last address plus 16 times (1 + source gap). Otherwise it advances by 16.
- R5: After a destination line's width of beats, the next write address is the line's last address plus 16 times (1 + destination gap). Otherwise it advances by 16. This happens independently of the source line position.
- R6: A request that is not accepted keeps its valid high with the same address and strobe. A read request and a write request are never valid in the same cycle.
- R7: In the cycle after the final write is accepted, busy and start read 0, done reads 1 and irq is high. Exactly ceil(count/16) beats are written.
- R8: Writing control with bit3 set and bit0 clear clears done and drops irq.
- R9: Starting with a zero source or destination width sets error, issues no read, and leaves irq low. The next valid start clears error.
- R10: Starting with a byte count of zero sets done in the next cycle with no beat moved.
- R11: While busy, writes to registers 0 to 3 and the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Completion interrupt, high while done is set |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Beat-aligned read address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 8*BEAT_BYTES | Read data beat |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Beat-aligned write address |
| wr_data | output | 8*BEAT_BYTES | Write data beat |
| wr_strb | output | BEAT_BYTES | Byte enables for the write |

## Verification
A wrong line counter or gap add on one side shows up as a wrong rd_req_addr or wr_addr on the first beat after that side's line end. That is at most one line of beats after the fault. A wrong remaining-byte count shows up in the final beat's strobe, or as a premature or late done in the cycle after the last write is accepted. Faults in start gating are visible as a read request that appears when the width is zero, or a restarted address sequence after a start written mid-transfer, within a few cycles of the offending register write.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int GSC_UNIT_W = 8;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_SIZE = 3'd2;
    localparam logic [2:0] REG_GEOM = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;

    localparam int CTRL_START = 0;
    localparam int CTRL_BUSY  = 1;
    localparam int CTRL_ERR   = 2;
    localparam int CTRL_DONE  = 3;

    typedef struct packed {
        logic [GSC_UNIT_W-1:0] out_gap;
        logic [GSC_UNIT_W-1:0] out_width;
        logic [GSC_UNIT_W-1:0] in_gap;
        logic [GSC_UNIT_W-1:0] in_width;
    } gsc_geom_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RREQ = 2'd1,
        ST_RDAT = 2'd2,
        ST_WR   = 2'd3
    } gsc_state_e;
endpackage

// File: rtl/gsc_regs.sv
module gsc_regs
    import gsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 24,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              err,
    input  logic              done,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [SIZE_W-1:0] xfer_size,
    output gsc_geom_t         geom,
    output logic              launch,
    output logic              done_clr
);
    localparam int SH = $clog2(BEAT_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [SIZE_W-1:0] size;
        gsc_geom_t         geom;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  cfg_open;
    logic  ctrl_wr;

    always_comb begin
        cfg_open = cfg_we && !busy;
        ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
        rg_d     = rg_q;
        if (cfg_open) begin
            unique case (cfg_addr)
                REG_SRC:  rg_d.src  = {cfg_wdata[ADDR_W-1:SH], {SH{1'b0}}};
                REG_DST:  rg_d.dst  = {cfg_wdata[ADDR_W-1:SH], {SH{1'b0}}};
                REG_SIZE: rg_d.size = cfg_wdata[SIZE_W-1:0];
                REG_GEOM: rg_d.geom = gsc_geom_t'(cfg_wdata);
                default:  ;
            endcase
        end
        launch   = ctrl_wr && !busy && cfg_wdata[CTRL_START];
        done_clr = ctrl_wr && cfg_wdata[CTRL_DONE] && !cfg_wdata[CTRL_START];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_SRC:  cfg_rdata[ADDR_W-1:0] = rg_q.src;
            REG_DST:  cfg_rdata[ADDR_W-1:0] = rg_q.dst;
            REG_SIZE: cfg_rdata[SIZE_W-1:0] = rg_q.size;
            REG_GEOM: cfg_rdata             = 32'(rg_q.geom);
            REG_CTRL: begin
                cfg_rdata[CTRL_START] = busy;
                cfg_rdata[CTRL_BUSY]  = busy;
                cfg_rdata[CTRL_ERR]   = err;
                cfg_rdata[CTRL_DONE]  = done;
            end
            default:  cfg_rdata = '0;
        endcase
    end

    assign src_base  = rg_q.src;
    assign dst_base  = rg_q.dst;
    assign xfer_size = rg_q.size;
    assign geom      = rg_q.geom;
endmodule

// File: rtl/gsc_stride.sv
module gsc_stride #(
    parameter int ADDR_W     = 32,
    parameter int UNIT_W     = 8,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [UNIT_W-1:0] width,
    input  logic [UNIT_W-1:0] gap,
    output logic [ADDR_W-1:0] addr
);
    localparam int SH = $clog2(BEAT_BYTES);
    localparam int PW = ADDR_W - SH;

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [UNIT_W-1:0] left;
    } stride_t;

    stride_t st_d, st_q;
    logic    line_end;

    always_comb begin
        st_d     = st_q;
        line_end = (st_q.left <= UNIT_W'(1));
        if (load) begin
            st_d.ptr  = base[ADDR_W-1:SH];
            st_d.left = width;
        end else if (step) begin
            if (line_end) begin
                st_d.ptr  = st_q.ptr + PW'(1) + PW'(gap);
                st_d.left = width;
            end else begin
                st_d.ptr  = st_q.ptr + PW'(1);
                st_d.left = st_q.left - UNIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = {st_q.ptr, {SH{1'b0}}};
endmodule

// File: rtl/gsc_ctrl.sv
module gsc_ctrl
    import gsc_pkg::*;
#(
    parameter int SIZE_W     = 24,
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    done_clr,
    input  logic                    cfg_bad,
    input  logic [SIZE_W-1:0]       xfer_size,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    input  logic                    rd_rvalid,
    input  logic [8*BEAT_BYTES-1:0] rd_rdata,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [8*BEAT_BYTES-1:0] wr_data,
    output logic [BEAT_BYTES-1:0]   wr_strb,
    output logic                    load,
    output logic                    step,
    output logic                    busy,
    output logic                    err,
    output logic                    done
);
    localparam int DATA_W = 8 * BEAT_BYTES;

    typedef struct packed {
        gsc_state_e        st;
        logic [SIZE_W-1:0] rem;
        logic [DATA_W-1:0] beat;
        logic              err;
        logic              done;
    } ctrl_t;

    ctrl_t cs_d, cs_q;
    logic  last_beat;

    always_comb begin
        cs_d      = cs_q;
        load      = 1'b0;
        step      = 1'b0;
        last_beat = (cs_q.rem <= SIZE_W'(BEAT_BYTES));
        if (done_clr) cs_d.done = 1'b0;
        unique case (cs_q.st)
            ST_IDLE: begin
                if (launch) begin
                    cs_d.done = 1'b0;
                    cs_d.err  = 1'b0;
                    if (cfg_bad) begin
                        cs_d.err = 1'b1;
                    end else if (xfer_size == '0) begin
                        cs_d.done = 1'b1;
                    end else begin
                        load     = 1'b1;
                        cs_d.rem = xfer_size;
                        cs_d.st  = ST_RREQ;
                    end
                end
            end
            ST_RREQ: begin
                if (rd_req_ready) cs_d.st = ST_RDAT;
            end
            ST_RDAT: begin
                if (rd_rvalid) begin
                    cs_d.beat = rd_rdata;
                    cs_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (wr_ready) begin
                    step = 1'b1;
                    if (last_beat) begin
                        cs_d.rem  = '0;
                        cs_d.done = 1'b1;
                        cs_d.st   = ST_IDLE;
                    end else begin
                        cs_d.rem = cs_q.rem - SIZE_W'(BEAT_BYTES);
                        cs_d.st  = ST_RREQ;
                    end
                end
            end
            default: cs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '{st: ST_IDLE, default: '0};
        else        cs_q <= cs_d;
    end

    always_comb begin
        for (int b = 0; b < BEAT_BYTES; b++) begin
            wr_strb[b] = (SIZE_W'(b) < cs_q.rem);
        end
    end

    assign rd_req_valid = (cs_q.st == ST_RREQ);
    assign wr_valid     = (cs_q.st == ST_WR);
    assign wr_data      = cs_q.beat;
    assign busy         = (cs_q.st != ST_IDLE);
    assign err          = cs_q.err;
    assign done         = cs_q.done;
endmodule

// File: rtl/gsc_dma.sv
module gsc_dma
    import gsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 24,
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic                    irq,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    output logic [ADDR_W-1:0]       rd_req_addr,
    input  logic                    rd_rvalid,
    input  logic [8*BEAT_BYTES-1:0] rd_rdata,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [8*BEAT_BYTES-1:0] wr_data,
    output logic [BEAT_BYTES-1:0]   wr_strb
);
    localparam int NSIDE = 2;

    logic              busy, err, done;
    logic              launch, done_clr, load, step, cfg_bad;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [SIZE_W-1:0] xfer_size;
    gsc_geom_t         geom;

    logic [ADDR_W-1:0]     side_base [NSIDE];
    logic [GSC_UNIT_W-1:0] side_width[NSIDE];
    logic [GSC_UNIT_W-1:0] side_gap  [NSIDE];
    logic [ADDR_W-1:0]     side_addr [NSIDE];

    gsc_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .err(err), .done(done),
        .src_base(src_base), .dst_base(dst_base), .xfer_size(xfer_size), .geom(geom),
        .launch(launch), .done_clr(done_clr)
    );

    assign cfg_bad = (geom.in_width == '0) || (geom.out_width == '0);

    gsc_ctrl #(.SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .done_clr(done_clr), .cfg_bad(cfg_bad), .xfer_size(xfer_size),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_strb(wr_strb),
        .load(load), .step(step), .busy(busy), .err(err), .done(done)
    );

    assign side_base[0]  = src_base;
    assign side_width[0] = geom.in_width;
    assign side_gap[0]   = geom.in_gap;
    assign side_base[1]  = dst_base;
    assign side_width[1] = geom.out_width;
    assign side_gap[1]   = geom.out_gap;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        gsc_stride #(.ADDR_W(ADDR_W), .UNIT_W(GSC_UNIT_W), .BEAT_BYTES(BEAT_BYTES)) u_stride (
            .clk(clk), .rst_n(rst_n),
            .load(load), .step(step),
            .base(side_base[s]), .width(side_width[s]), .gap(side_gap[s]),
            .addr(side_addr[s])
        );
    end

    assign rd_req_addr = side_addr[0];
    assign wr_addr     = side_addr[1];
    assign irq         = done;
endmodule

// File: rtl/gsc_dma_chk.sv
module gsc_dma_chk #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_req_valid,
    input logic                  rd_req_ready,
    input logic [ADDR_W-1:0]     rd_req_addr,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [BEAT_BYTES-1:0] wr_strb,
    input logic                  irq,
    input logic                  busy,
    input logic                  err
);
    a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_strb));

    a_r6_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && wr_valid));

    a_r3_strb_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_strb[0] && ((BEAT_BYTES'(wr_strb + 1'b1) & wr_strb) == '0));

    a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    a_r9_err_noread: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rd_req_valid && !irq);

    a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && $past(busy) |-> $past(wr_valid && wr_ready));
endmodule

bind gsc_dma gsc_dma_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .irq(irq), .busy(busy), .err(err)
);

// File: tb/gsc_dma_test.sv
module gsc_dma_test;
    localparam int NV = 5;
    localparam logic [31:0] V_SRC [NV] = '{32'h0000_1000, 32'h0002_0040, 32'h0003_0000, 32'h0000_7000, 32'h0001_0100};
    localparam logic [31:0] V_DST [NV] = '{32'h0000_8000, 32'h0004_0000, 32'h0005_0010, 32'h0000_9000, 32'h0006_0200};
    localparam int V_SIZE [NV] = '{96, 50, 200, 16, 129};
    localparam int V_IW [NV] = '{2, 1, 4, 3, 1};
    localparam int V_IG [NV] = '{1, 0, 3, 0, 7};
    localparam int V_OW [NV] = '{3, 1, 2, 3, 5};
    localparam int V_OG [NV] = '{0, 2, 5, 0, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic irq, rd_req_valid, rd_req_ready = 1'b0, rd_rvalid = 1'b0;
    logic [31:0] rd_req_addr, wr_addr;
    logic [127:0] rd_rdata = '0, wr_data;
    logic wr_valid, wr_ready = 1'b0;
    logic [15:0] wr_strb;

    int errors = 0, checks = 0;
    int reads_seen = 0, beats_seen = 0;
    logic [31:0] ex_src, ex_dst;
    int ex_rem, ex_il, ex_ol, m_iw, m_ig, m_ow, m_og;

    always #4 clk = ~clk;

    gsc_dma uut (.*);

    function automatic logic [127:0] pat(input logic [31:0] a);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(a[11:4] * 3) ^ 8'(i * 29) ^ a[19:12];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Memory responder and beat checker
    initial begin
        int tick = 0;
        logic pend = 1'b0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            tick++;
            rd_rvalid = 1'b0;
            if (pend) begin
                rd_rvalid = 1'b1; rd_rdata = pat(paddr); pend = 1'b0;
            end
            rd_req_ready = (tick % 3) != 0;
            if (rd_req_valid && rd_req_ready) begin
                pend = 1'b1; paddr = rd_req_addr; reads_seen++;
                chk(rd_req_addr == ex_src, "R4 source address", 128'(rd_req_addr), 128'(ex_src));
            end
            wr_ready = (tick % 4) != 1;
            if (wr_valid && wr_ready) begin
                logic [15:0] es;
                logic [127:0] ed;
                es = (ex_rem >= 16) ? 16'hFFFF : 16'((1 << ex_rem) - 1);
                ed = pat(ex_src);
                chk(wr_addr == ex_dst, "R5 destination address", 128'(wr_addr), 128'(ex_dst));
                chk(wr_strb == es, "R3 strobe", 128'(wr_strb), 128'(es));
                for (int b = 0; b < 16; b++) if (!es[b]) begin ed[b*8 +: 8] = 8'h0; end
                for (int b = 0; b < 16; b++) if (!es[b]) begin wr_data[b*8 +: 8] = wr_data[b*8 +: 8]; end
                chk((wr_data & {{8{es[15]}},{8{es[14]}},{8{es[13]}},{8{es[12]}},{8{es[11]}},{8{es[10]}},
                               {8{es[9]}},{8{es[8]}},{8{es[7]}},{8{es[6]}},{8{es[5]}},{8{es[4]}},
                               {8{es[3]}},{8{es[2]}},{8{es[1]}},{8{es[0]}}}) == ed,
                    "R3 data", wr_data, ed);
                beats_seen++;
                ex_rem = (ex_rem > 16) ? ex_rem - 16 : 0;
                ex_il--; ex_ol--;
                if (ex_il == 0) begin ex_il = m_iw; ex_src += 32'((1 + m_ig) * 16); end
                else ex_src += 32'd16;
                if (ex_ol == 0) begin ex_ol = m_ow; ex_dst += 32'((1 + m_og) * 16); end
                else ex_dst += 32'd16;
            end
        end
    end

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int sz,
                         input int iw, input int ig, input int ow, input int og);
        wr_reg(3'd0, s); wr_reg(3'd1, d); wr_reg(3'd2, 32'(sz));
        wr_reg(3'd3, {8'(og), 8'(ow), 8'(ig), 8'(iw)});
        ex_src = s; ex_dst = d; ex_rem = sz;
        m_iw = iw; m_ig = ig; m_ow = ow; m_og = og; ex_il = iw; ex_ol = ow;
        beats_seen = 0; reads_seen = 0;
    endtask

    task automatic wait_irq;
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    task automatic finish_checks(input int sz);
        logic [31:0] r;
        chk(irq == 1'b1, "R7 irq", 128'(irq), 128'(1));
        chk(beats_seen == (sz + 15) / 16, "R7 beat count", 128'(beats_seen), 128'((sz + 15) / 16));
        rd_reg(3'd4, r);
        chk(r[3:0] == 4'b1000, "R7 status after completion", 128'(r[3:0]), 128'(4'b1000));
        wr_reg(3'd4, 32'h8);
        chk(irq == 1'b0, "R8 done clear", 128'(irq), 128'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        ex_src = '0; ex_dst = '0; ex_rem = 0; ex_il = 1; ex_ol = 1;
        m_iw = 1; m_ig = 0; m_ow = 1; m_og = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0 && rd_req_valid == 1'b0 && wr_valid == 1'b0, "R1 outputs", 128'({irq, rd_req_valid, wr_valid}), 128'(0));
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), r);
            chk(r == 32'h0, "R1 register reset", 128'(r), 128'(0));
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2 alignment of bases
        wr_reg(3'd0, 32'h1234_567F);
        rd_reg(3'd0, r);
        chk(r == 32'h1234_5670, "R2 source base low bits", 128'(r), 128'(32'h1234_5670));
        wr_reg(3'd3, 32'hA1B2C3D4);
        rd_reg(3'd3, r);
        chk(r == 32'hA1B2C3D4, "R2 geometry readback", 128'(r), 128'(32'hA1B2C3D4));

        // Table-driven transfers: R3 R4 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            setup(V_SRC[v], V_DST[v], V_SIZE[v], V_IW[v], V_IG[v], V_OW[v], V_OG[v]);
            wr_reg(3'd4, 32'h1);
            wait_irq();
            finish_checks(V_SIZE[v]);
        end

        // R9 zero width
        setup(32'h100, 32'h200, 64, 0, 1, 2, 0);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, r);
        chk(r[3:0] == 4'b0100, "R9 error flag", 128'(r[3:0]), 128'(4'b0100));
        repeat (10) @(negedge clk);
        chk(reads_seen == 0 && irq == 1'b0, "R9 no transfer", 128'({reads_seen, irq}), 128'(0));
        setup(32'h100, 32'h200, 48, 1, 0, 0, 0);
        wr_reg(3'd4, 32'h1);
        repeat (10) @(negedge clk);
        chk(reads_seen == 0, "R9 zero output width", 128'(reads_seen), 128'(0));
        setup(32'h300, 32'h400, 32, 1, 1, 1, 1);
        wr_reg(3'd4, 32'h1);
        wait_irq();
        rd_reg(3'd4, r);
        chk(r[2] == 1'b0, "R9 error cleared by good start", 128'(r[2]), 128'(0));
        finish_checks(32);

        // R10 zero size
        setup(32'h500, 32'h600, 0, 1, 0, 1, 0);
        wr_reg(3'd4, 32'h1);
        chk(irq == 1'b1, "R10 immediate done", 128'(irq), 128'(1));
        repeat (5) @(negedge clk);
        chk(beats_seen == 0 && reads_seen == 0, "R10 no beats", 128'(beats_seen), 128'(0));
        wr_reg(3'd4, 32'h8);

        // R11 writes ignored while busy
        setup(32'h2000, 32'hA000, 160, 3, 2, 4, 1);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, r);
        chk(r[1:0] == 2'b11, "R11 busy readable", 128'(r[1:0]), 128'(2'b11));
        wr_reg(3'd3, 32'h0101_0101);
        wr_reg(3'd0, 32'h7770);
        wr_reg(3'd2, 32'd16);
        wr_reg(3'd4, 32'h1);
        wait_irq();
        finish_checks(160);
        rd_reg(3'd3, r);
        chk(r == {8'd1, 8'd4, 8'd2, 8'd3}, "R11 geometry kept", 128'(r), 128'({8'd1, 8'd4, 8'd2, 8'd3}));
        rd_reg(3'd0, r);
        chk(r == 32'h2000, "R11 source kept", 128'(r), 128'(32'h2000));
        rd_reg(3'd2, r);
        chk(r == 32'd160, "R11 size kept", 128'(r), 128'(160));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule